// File: doc/BRIEF.md
# Serial Divider-Word Loader

This block takes divider settings for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. It runs on a fast system clock and resynchronises all three wires. Bits enter most significant first on each rising edge of the serial clock and collect in a 19-bit shift register.

A rising edge on the load strobe commits the collected word. Its final bit selects the destination. One destination holds a reference divide ratio and a prescaler modulus select. The other holds the swallow count and the main count.

Words with prohibited values are rejected as a whole. The latched registers keep their previous contents and an error flag rises. The registered outputs change only when a load is accepted.

Top module: `synth_word_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into the shift register, most significant bit first. Only the last 19 bits shifted before a load count, so extra leading bits are discarded.
- R2: A load whose bit 0 is 1 writes bits 14..1 to `ref_div` and bit 15 to `pre_sel`. In `pre_sel`, 0 selects modulus 128/129 and 1 selects 64/65. Such a load leaves `swal_cnt` and `main_cnt` untouched.
- R3: A load whose bit 0 is 0 writes bits 7..1 to `swal_cnt` and bits 18..8 to `main_cnt`. Such a load leaves `ref_div` and `pre_sel` untouched.
- R4: A reference load whose ratio is below 3 is rejected: `cfg_err` goes to 1 and `ref_div` and `pre_sel` keep their values.
- R5: A counter load is rejected in the same way if its main value is below 3 or its swallow value exceeds its main value.
- R6: The outputs change only after a rising edge of `ser_le`. Shifting bits without a load leaves every output unchanged.
- R7: An accepted load clears `cfg_err`. The flag then holds its value until the next load.
- R8: After reset, `ref_div` = 3, `main_cnt` = 3, `swal_cnt` = 0, `pre_sel` = 0 and `cfg_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; its rising edge commits the word |
| ref_div | output | 14 | Reference divide ratio |
| pre_sel | output | 1 | Prescaler modulus select (0: 128/129, 1: 64/65) |
| swal_cnt | output | 7 | Swallow counter preset |
| main_cnt | output | 11 | Main counter preset |
| cfg_err | output | 1 | Last load was rejected |

## Verification
Several properties are checked on every cycle:
- the latched ratios never fall below their legal floors;
- the swallow value never exceeds the main value;
- no output moves without a load strobe;
- a rising error flag coincides with unchanged latches;
- the flag clears only on a load.

Other behaviour is shown only by the bench's scenarios: the bit order and field placement of each word, which latch group a control bit selects, and how leading extra bits are discarded.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int WORD_W  = 19;
  localparam int REF_W   = 14;
  localparam int SWAL_W  = 7;
  localparam int MAIN_W  = 11;
  localparam int MIN_DIV = 3;

  typedef struct packed {
    logic              is_ref;
    logic [REF_W-1:0]  ref_div;
    logic              pre_sel;
    logic [SWAL_W-1:0] swal;
    logic [MAIN_W-1:0] main;
    logic              ok;
  } dec_word_t;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sld_shift.sv
module sld_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sld_decode.sv
module sld_decode
  import sld_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_word_t         dec
);
  always_comb begin
    dec.is_ref  = word[0];
    dec.ref_div = word[REF_W:1];
    dec.pre_sel = word[REF_W+1];
    dec.swal    = word[SWAL_W:1];
    dec.main    = word[WORD_W-1:SWAL_W+1];
    if (dec.is_ref)
      dec.ok = int'(dec.ref_div) >= MIN_DIV;
    else
      dec.ok = (int'(dec.main) >= MIN_DIV) && (int'(dec.swal) <= int'(dec.main));
  end
endmodule

// File: rtl/synth_word_loader.sv
module synth_word_loader
  import sld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_div,
  output logic              pre_sel,
  output logic [SWAL_W-1:0] swal_cnt,
  output logic [MAIN_W-1:0] main_cnt,
  output logic              cfg_err
);
  logic [2:0] pins_s;
  logic       sclk_d, le_d;
  logic       sclk_rise, le_rise;
  logic [WORD_W-1:0] word;
  dec_word_t  dec;

  sld_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_le, ser_clk, ser_data}),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= pins_s[1];
      le_d   <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[1] & ~sclk_d;
  assign le_rise   = pins_s[2] & ~le_d;

  sld_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (sclk_rise),
    .bit_in   (pins_s[0]),
    .word     (word)
  );

  sld_decode u_dec (
    .word (word),
    .dec  (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_div  <= REF_W'(MIN_DIV);
      pre_sel  <= 1'b0;
      swal_cnt <= '0;
      main_cnt <= MAIN_W'(MIN_DIV);
      cfg_err  <= 1'b0;
    end else if (le_rise) begin
      cfg_err <= ~dec.ok;
      if (dec.ok) begin
        if (dec.is_ref) begin
          ref_div <= dec.ref_div;
          pre_sel <= dec.pre_sel;
        end else begin
          swal_cnt <= dec.swal;
          main_cnt <= dec.main;
        end
      end
    end
  end
endmodule

// File: rtl/sld_checker.sv
module sld_checker
  import sld_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              le_rise,
  input logic [REF_W-1:0]  ref_div,
  input logic              pre_sel,
  input logic [SWAL_W-1:0] swal_cnt,
  input logic [MAIN_W-1:0] main_cnt,
  input logic              cfg_err
);
  p_ref_floor_r4: assert property (@(posedge clk) disable iff (rst)
    int'(ref_div) >= MIN_DIV);

  p_counter_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(main_cnt) >= MIN_DIV) && (swal_cnt <= SWAL_W'(main_cnt) || int'(main_cnt) > 127));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !le_rise |=> ($stable(ref_div) && $stable(pre_sel) && $stable(swal_cnt)
                  && $stable(main_cnt) && $stable(cfg_err)));

  p_reject_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err) |-> ($stable(ref_div) && $stable(pre_sel)
                        && $stable(swal_cnt) && $stable(main_cnt)));

  p_clear_on_load_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_err) |-> $past(le_rise));
endmodule

bind synth_word_loader sld_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .le_rise  (le_rise),
  .ref_div  (ref_div),
  .pre_sel  (pre_sel),
  .swal_cnt (swal_cnt),
  .main_cnt (main_cnt),
  .cfg_err  (cfg_err)
);

// File: tb/test_synth_word_loader.sv
module test_synth_word_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel;
  logic [6:0]  swal_cnt;
  logic [10:0] main_cnt;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [13:0] e_ref = 14'd3;
  logic        e_pre = 1'b0;
  logic [6:0]  e_swal = 7'd0;
  logic [10:0] e_main = 11'd3;
  logic        e_err = 1'b0;

  always #2 clk = ~clk;

  synth_word_loader i_synth_word_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_div(ref_div), .pre_sel(pre_sel), .swal_cnt(swal_cnt),
    .main_cnt(main_cnt), .cfg_err(cfg_err)
  );

  // Vector = {expected reject, 19-bit word}
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 3'b000, 1'b1, 14'd1000, 1'b1},  // R2 ref 1000, 64/65
    {1'b0, 11'd500, 7'd20, 1'b0},          // R3 main 500, swallow 20
    {1'b1, 3'b000, 1'b0, 14'd2, 1'b1},     // R4 ref 2 rejected
    {1'b1, 11'd2, 7'd0, 1'b0},             // R5 main 2 rejected
    {1'b1, 11'd10, 7'd11, 1'b0},           // R5 swallow > main rejected
    {1'b0, 11'd10, 7'd10, 1'b0},           // R5 swallow == main accepted
    {1'b0, 3'b000, 1'b0, 14'd3, 1'b1},     // R4 ref 3 accepted, 128/129
    {1'b0, 3'b000, 1'b1, 14'd16383, 1'b1}, // R2 max ref
    {1'b0, 11'd2047, 7'd127, 1'b0},        // R3 max counters
    {1'b1, 3'b000, 1'b1, 14'd0, 1'b1}      // R4 ref 0 rejected
  };

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [31:0] w, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
      wait_clk(3);
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_clk(5);
    ser_le = 1'b0;
    wait_clk(6);
  endtask

  task automatic model(logic [18:0] w);
    if (w[0]) begin
      if (w[14:1] >= 14'd3) begin
        e_ref = w[14:1]; e_pre = w[15]; e_err = 1'b0;
      end else e_err = 1'b1;
    end else begin
      if (w[18:8] >= 11'd3 && {4'b0, w[7:1]} <= w[18:8]) begin
        e_swal = w[7:1]; e_main = w[18:8]; e_err = 1'b0;
      end else e_err = 1'b1;
    end
  endtask

  task automatic check_all(string req);
    chk(req, "ref_div", int'(ref_div), int'(e_ref));
    chk(req, "pre_sel", int'(pre_sel), int'(e_pre));
    chk(req, "swal_cnt", int'(swal_cnt), int'(e_swal));
    chk(req, "main_cnt", int'(main_cnt), int'(e_main));
    chk(req, "cfg_err", int'(cfg_err), int'(e_err));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main_seq
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    check_all("R8");

    for (int v = 0; v < 10; v++) begin
      send_bits({13'b0, VEC[v][18:0]}, 19);
      pulse_le();
      chk(VEC[v][19] ? "R4/R5" : "R7", "reject flag", int'(cfg_err), int'(VEC[v][19]));
      model(VEC[v][18:0]);
      check_all(VEC[v][0] ? "R2" : "R3");
    end

    // R6: shift a full word with no load strobe, nothing may change
    send_bits({13'b0, 3'b000, 1'b0, 14'd555, 1'b1}, 19);
    wait_clk(6);
    check_all("R6");

    // R1: four extra leading ones are pushed out, last 19 bits are kept
    send_bits({9'b0, 4'b1111, 3'b000, 1'b0, 14'd77, 1'b1}, 23);
    pulse_le();
    model({3'b000, 1'b0, 14'd77, 1'b1});
    check_all("R1");

    // R7: error flag holds until the next load, then an accepted load clears it
    send_bits({13'b0, 11'd1, 7'd0, 1'b0}, 19);
    pulse_le();
    model({11'd1, 7'd0, 1'b0});
    wait_clk(20);
    chk("R7", "flag held", int'(cfg_err), 1);
    send_bits({13'b0, 11'd40, 7'd5, 1'b0}, 19);
    pulse_le();
    model({11'd40, 7'd5, 1'b0});
    check_all("R7");

    // R8: reset again restores defaults
    rst = 1'b1;
    wait_clk(3);
    rst = 1'b0;
    wait_clk(2);
    e_ref = 14'd3; e_pre = 1'b0; e_swal = 7'd0; e_main = 11'd3; e_err = 1'b0;
    check_all("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule